// File: doc/BRIEF.md
# Serial Load and Capture Shift Chain

This block moves whole bit planes between a serial pin pair and a rectangular array of cells. On the input side, every cell owns two flops, a pixel flop and a marker flop. These flops are strung into one long shift register, so a pixel plane and an initial-marker plane can be loaded one bit per enabled clock. The loaded planes drive the array in parallel.

On the output side, every cell owns one more flop, fed through a two-way multiplexer. When a strobe arrives with the select set to local, each flop samples its own cell's result. This gives a snapshot that can be taken at any moment, including while a wave is still running through the array. Strobes with the select set to chain then move the snapshot one cell per strobe towards the serial output, with zeros entering at the head. A one-cycle done pulse marks the strobe that removes the last captured bit. The propagation logic itself is outside this block and appears only as the parallel result input.

Top module: `cell_io_chain`

## Requirements
- R1: While rst_ni is low, and right after it rises, both planes, sdata_o and frame_done_o are 0.
- R2: Cells are indexed row-major, and cell c is bit c of each plane. The input chain runs sdata_i, then pixel[0], then marker[0], then pixel[1], and so on to marker[CELLS-1]. On every clock with shift_in_i high, each flop takes the value of its predecessor. After 2*CELLS shifts, the first bit sent sits in marker[CELLS-1] and the last bit sent sits in pixel[0].
- R3: With shift_in_i low, neither plane changes, whatever sdata_i does.
- R4: A clock with cap_strobe_i high and cap_sel_i = 1 (local) loads result_i into the output flops. From the next cycle, sdata_o shows the result of cell CELLS-1.
- R5: A clock with cap_strobe_i high and cap_sel_i = 0 (chain) moves every output flop one place towards cell CELLS-1, and cell 0 takes 0. After j such shifts following a capture, sdata_o shows the captured bit of cell CELLS-1-j. Once the captured bits are exhausted, it shows 0.
- R6: With cap_strobe_i low, the output flops and sdata_o hold, whatever result_i and cap_sel_i do.
- R7: The input chain and the output chain are independent. Loading and capturing or shifting in the same cycle each behave as if done alone, and a capture in the middle of a readout restarts that readout.
- R8: frame_done_o is high for exactly one cycle, following the CELLS-th chain shift after the most recent capture. It does not pulse again before another capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial input bit |
| shift_in_i | input | 1 | Advance the input chain by one bit |
| pix_plane_o | output | ROWS*COLS | Pixel plane presented to the array |
| mark_plane_o | output | ROWS*COLS | Initial-marker plane presented to the array |
| result_i | input | ROWS*COLS | Result plane from the array |
| cap_strobe_i | input | 1 | Clock enable of the output flops |
| cap_sel_i | input | 1 | 1: load local result, 0: shift from neighbour |
| sdata_o | output | 1 | Serial output bit (output flop of cell CELLS-1) |
| frame_done_o | output | 1 | One-cycle pulse after the last captured bit has left |

## Verification
Every cycle, the assertions check the single-step relations: one-place movement of the input chain, hold of the input planes when not enabled, a whole-plane load on capture, a one-place shift with zero fill on chain strobes, hold of the output without a strobe, and a done pulse that never lasts two cycles. Only the bench scenarios show properties that span many cycles. These are the bit order of a full 2*CELLS-bit load, the serial order of a full readout, the timing of the single done pulse after exactly CELLS shifts, and the restart of a readout by a capture taken mid-stream while input loading runs at the same time.

// File: rtl/cell_io_pkg.sv
package cell_io_pkg;
  typedef enum logic {
    OSEL_CHAIN = 1'b0,
    OSEL_LOCAL = 1'b1
  } osel_e;
endpackage

// File: rtl/cio_in_chain.sv
module cio_in_chain #(
  parameter int CELLS = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             sdata_i,
  output logic [CELLS-1:0] pix_o,
  output logic [CELLS-1:0] mark_o
);
  logic [CELLS-1:0] pix_q, mark_q;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic pix_d;
    if (c == 0) begin : g_head
      assign pix_d = sdata_i;
    end else begin : g_body
      assign pix_d = mark_q[c-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pix_q[c]  <= 1'b0;
        mark_q[c] <= 1'b0;
      end else if (shift_en_i) begin
        pix_q[c]  <= pix_d;
        mark_q[c] <= pix_q[c];
      end
    end
  end

  assign pix_o  = pix_q;
  assign mark_o = mark_q;
endmodule

// File: rtl/cio_out_chain.sv
module cio_out_chain
  import cell_io_pkg::*;
#(
  parameter int CELLS = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  osel_e            sel_i,
  input  logic [CELLS-1:0] result_i,
  output logic [CELLS-1:0] bits_o
);
  logic [CELLS-1:0] bits_q;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic nbr, nxt;
    if (c == 0) begin : g_head
      assign nbr = 1'b0;
    end else begin : g_body
      assign nbr = bits_q[c-1];
    end
    assign nxt = (sel_i == OSEL_LOCAL) ? result_i[c] : nbr;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bits_q[c] <= 1'b0;
      else if (strobe_i) bits_q[c] <= nxt;
    end
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/cio_frame_ctr.sv
module cio_frame_ctr #(
  parameter int CELLS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic shift_i,
  output logic done_o
);
  localparam int CW = $clog2(CELLS + 1);
  localparam logic [CW-1:0] IDLE = CW'(CELLS);
  localparam logic [CW-1:0] LAST = CW'(CELLS - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  // cnt_q saturates at IDLE: no pulse until the next capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= shift_i && !cap_i && (cnt_q == LAST);
      if (cap_i)                        cnt_q <= '0;
      else if (shift_i && cnt_q != IDLE) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/cell_io_chain.sv
module cell_io_chain
  import cell_io_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sdata_i,
  input  logic                 shift_in_i,
  output logic [ROWS*COLS-1:0] pix_plane_o,
  output logic [ROWS*COLS-1:0] mark_plane_o,
  input  logic [ROWS*COLS-1:0] result_i,
  input  logic                 cap_strobe_i,
  input  logic                 cap_sel_i,
  output logic                 sdata_o,
  output logic                 frame_done_o
);
  localparam int CELLS = ROWS * COLS;

  osel_e            osel;
  logic [CELLS-1:0] out_bits;
  logic             cap_load, cap_shift;

  assign osel      = osel_e'(cap_sel_i);
  assign cap_load  = cap_strobe_i && (osel == OSEL_LOCAL);
  assign cap_shift = cap_strobe_i && (osel == OSEL_CHAIN);

  cio_in_chain #(.CELLS(CELLS)) i_in_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_in_i),
    .sdata_i    (sdata_i),
    .pix_o      (pix_plane_o),
    .mark_o     (mark_plane_o)
  );

  cio_out_chain #(.CELLS(CELLS)) i_out_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (cap_strobe_i),
    .sel_i    (osel),
    .result_i (result_i),
    .bits_o   (out_bits)
  );

  cio_frame_ctr #(.CELLS(CELLS)) i_frame_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap_load),
    .shift_i (cap_shift),
    .done_o  (frame_done_o)
  );

  assign sdata_o = out_bits[CELLS-1];
endmodule

// File: rtl/cio_chain_chk.sv
module cio_chain_chk #(
  parameter int CELLS = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sdata_i,
  input logic             shift_in_i,
  input logic [CELLS-1:0] pix_plane_o,
  input logic [CELLS-1:0] mark_plane_o,
  input logic [CELLS-1:0] result_i,
  input logic             cap_strobe_i,
  input logic             cap_sel_i,
  input logic             sdata_o,
  input logic             frame_done_o,
  input logic [CELLS-1:0] out_bits
);
  a_r2_in_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_in_i |=> pix_plane_o == {$past(mark_plane_o[CELLS-2:0]), $past(sdata_i)}
                && mark_plane_o == $past(pix_plane_o));

  a_r3_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_in_i |=> $stable(pix_plane_o) && $stable(mark_plane_o));

  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_strobe_i && cap_sel_i) |=> out_bits == $past(result_i));

  a_r5_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_strobe_i && !cap_sel_i) |=> out_bits[CELLS-1:1] == $past(out_bits[CELLS-2:0])
                                  && !out_bits[0]);

  a_r6_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_strobe_i |=> $stable(out_bits) && $stable(sdata_o));

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
endmodule

bind cell_io_chain cio_chain_chk #(.CELLS(ROWS*COLS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sdata_i      (sdata_i),
  .shift_in_i   (shift_in_i),
  .pix_plane_o  (pix_plane_o),
  .mark_plane_o (mark_plane_o),
  .result_i     (result_i),
  .cap_strobe_i (cap_strobe_i),
  .cap_sel_i    (cap_sel_i),
  .sdata_o      (sdata_o),
  .frame_done_o (frame_done_o),
  .out_bits     (out_bits)
);

// File: tb/test_cell_io_chain.sv
module test_cell_io_chain;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int N = ROWS * COLS;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sdata_in = 1'b0;
  logic         shift_in = 1'b0;
  logic [N-1:0] pix_plane, mark_plane;
  logic [N-1:0] result = '0;
  logic         cap_strobe = 1'b0;
  logic         cap_sel = 1'b0;
  logic         sdata_out, frame_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_io_chain #(.ROWS(ROWS), .COLS(COLS)) i_cell_io_chain (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sdata_i      (sdata_in),
    .shift_in_i   (shift_in),
    .pix_plane_o  (pix_plane),
    .mark_plane_o (mark_plane),
    .result_i     (result),
    .cap_strobe_i (cap_strobe),
    .cap_sel_i    (cap_sel),
    .sdata_o      (sdata_out),
    .frame_done_o (frame_done)
  );

  // Reference model: history of input bits, queue of pending output bits
  bit in_hist[$];
  bit out_q[$];
  int shifts_since_cap = N;
  bit done_exp = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hist.delete();
      out_q.delete();
      for (int k = 0; k < N; k++) out_q.push_back(1'b0);
      shifts_since_cap = N;
      done_exp = 1'b0;
    end else begin
      if (shift_in) begin
        in_hist.push_front(sdata_in);
        if (in_hist.size() > 2*N) void'(in_hist.pop_back());
      end
      done_exp = 1'b0;
      if (cap_strobe) begin
        if (cap_sel) begin
          out_q.delete();
          for (int k = N-1; k >= 0; k--) out_q.push_back(result[k]);
          shifts_since_cap = 0;
        end else begin
          void'(out_q.pop_front());
          out_q.push_back(1'b0);
          if (shifts_since_cap < N) begin
            shifts_since_cap++;
            if (shifts_since_cap == N) done_exp = 1'b1;
          end
        end
      end
    end
  end

  function automatic logic [N-1:0] exp_plane(int ofs);
    logic [N-1:0] v = '0;
    for (int c = 0; c < N; c++)
      if (2*c + ofs < in_hist.size()) v[c] = in_hist[2*c + ofs];
    return v;
  endfunction

  task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(pix_plane == exp_plane(0), "R2 pixel plane", 64'(pix_plane), 64'(exp_plane(0)));
      check(mark_plane == exp_plane(1), "R2 marker plane", 64'(mark_plane), 64'(exp_plane(1)));
      check(sdata_out == out_q[0], "R5 sdata_o", 64'(sdata_out), 64'(out_q[0]));
      check(frame_done == done_exp, "R8 frame_done_o", 64'(frame_done), 64'(done_exp));
    end
  end

  task automatic send_bit(logic b);
    sdata_in = b;
    shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
  endtask

  task automatic load_frame(logic [N-1:0] pix, logic [N-1:0] mark);
    for (int c = N-1; c >= 0; c--) begin
      send_bit(mark[c]);
      send_bit(pix[c]);
    end
  endtask

  task automatic strobe(logic sel);
    cap_sel = sel;
    cap_strobe = 1'b1;
    @(negedge clk);
    cap_strobe = 1'b0;
  endtask

  localparam logic [N-1:0] PIX_A  = 24'hA5C3_1E;
  localparam logic [N-1:0] MARK_A = 24'h0F00_81;
  localparam logic [N-1:0] RES_A  = 24'hC00F_35;
  localparam logic [N-1:0] RES_B  = 24'h5A5A_A5;
  localparam logic [N-1:0] RES_C  = 24'h8000_01;
  localparam logic [N-1:0] PIX_B  = 24'h1234_56;
  localparam logic [N-1:0] MARK_B = 24'hFEDC_BA;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    check(pix_plane == '0 && mark_plane == '0, "R1 planes in reset",
          64'({pix_plane, mark_plane}), 64'(0));
    check(!sdata_out && !frame_done, "R1 outputs in reset",
          64'({sdata_out, frame_done}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(pix_plane == '0 && !sdata_out && !frame_done, "R1 after release",
          64'({pix_plane, sdata_out, frame_done}), 64'(0));

    // R2: full load bit order
    load_frame(PIX_A, MARK_A);
    check(pix_plane == PIX_A, "R2 full load pixel", 64'(pix_plane), 64'(PIX_A));
    check(mark_plane == MARK_A, "R2 full load marker", 64'(mark_plane), 64'(MARK_A));

    // R3: serial input toggles with shift disabled
    for (int i = 0; i < 6; i++) begin
      sdata_in = ~sdata_in;
      @(negedge clk);
    end
    check(pix_plane == PIX_A && mark_plane == MARK_A, "R3 planes hold",
          64'(pix_plane), 64'(PIX_A));

    // R4: capture
    result = RES_A;
    strobe(1'b1);
    check(sdata_out == RES_A[N-1], "R4 first bit after capture", 64'(sdata_out), 64'(RES_A[N-1]));

    // R6: result and select change without strobe
    result = ~RES_A;
    for (int i = 0; i < 4; i++) begin
      cap_sel = ~cap_sel;
      @(negedge clk);
    end
    check(sdata_out == RES_A[N-1], "R6 output holds", 64'(sdata_out), 64'(RES_A[N-1]));

    // R5 / R8: full readout
    for (int j = 0; j < N; j++) begin
      check(sdata_out == RES_A[N-1-j], "R5 readout order", 64'(sdata_out), 64'(RES_A[N-1-j]));
      strobe(1'b0);
      if (j == N-1) check(frame_done == 1'b1, "R8 pulse after last shift", 64'(frame_done), 64'(1));
      else check(frame_done == 1'b0, "R8 no early pulse", 64'(frame_done), 64'(0));
    end
    @(negedge clk);
    check(frame_done == 1'b0, "R8 pulse one cycle", 64'(frame_done), 64'(0));
    strobe(1'b0);
    strobe(1'b0);
    check(sdata_out == 1'b0, "R5 zero fill", 64'(sdata_out), 64'(0));
    check(frame_done == 1'b0, "R8 no second pulse", 64'(frame_done), 64'(0));

    // R7: concurrent load and capture, mid-stream restart
    result = RES_B;
    cap_sel = 1'b1;
    cap_strobe = 1'b1;
    send_bit(MARK_B[N-1]);
    cap_strobe = 1'b0;
    check(sdata_out == RES_B[N-1], "R7 capture during load", 64'(sdata_out), 64'(RES_B[N-1]));
    pulses = 0;
    for (int j = 0; j < 5; j++) begin
      strobe(1'b0);
      if (frame_done) pulses++;
    end
    result = RES_C;
    strobe(1'b1);
    for (int c = N-1; c >= 0; c--) begin
      if (c != N-1) send_bit(MARK_B[c]);
      cap_sel = 1'b0;
      cap_strobe = 1'b1;
      send_bit(PIX_B[c]);
      cap_strobe = 1'b0;
      if (frame_done) pulses++;
    end
    @(negedge clk);
    if (frame_done) pulses++;
    check(pulses == 1, "R8 one pulse per restarted readout", 64'(pulses), 64'(1));
    check(pix_plane == PIX_B && mark_plane == MARK_B, "R7 load unaffected by readout",
          64'(pix_plane), 64'(PIX_B));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule